// File: doc/BRIEF.md
# Address Translation Front-End Sequencer

This block sits in front of a page-table walker. It takes one translation request at a time: a 64-bit effective address, an access type and the two relocation mode bits. It then returns exactly one answer. That answer is either a real address with a page size and permissions, or a classified fault that carries a cause word and a fault address.

The block settles the cheap cases itself.
- **Real mode:** when relocation is off, it answers directly.
- **Illegal address region:** the top two address bits select a region. If the region is illegal, it raises a segment fault.
- **Out-of-range process table slot:** if the slot index falls outside the table, it raises a storage fault.

Otherwise it reads one 64-bit process-table entry through a single-outstanding memory read port. It decodes that entry into a walk seed and hands the seed to an external walker. The walker's result or fault is then formatted into the response.

Requests and responses use valid/ready handshakes. Every response is held in a register until it is taken.

Top module: `xlate_frontend`

## Requirements
- R1: During and after reset `req_ready` is 1 and `rsp_valid`, `mem_req_valid` and `walk_start` are 0.
- R2: Access code 2'b11 gives kind 5 (bad access), cause 0 and fault address equal to the request address. No memory read is made.
- R3: Access codes are 2'b00 read, 2'b01 write and 2'b10 fetch. When relocation is off, the response follows on the cycle after acceptance with kind 0 and no memory read. Relocation is off for a fetch when `req_ir` is 0, and for a read or write when `req_dr` is 0. The response carries `rsp_raddr` = address with bits 63:60 cleared, `rsp_psize` = REAL_PSIZE (12) and `rsp_perm` = 3'b111.
- R4: The region is address bits 63:62. Region 0 uses `cur_pid` and region 3 uses process id 0. The table read address is `ptab_base` + 16 × id.
- R5: In virtual mode, regions 1 and 2 fault with cause 0 and no memory read. A fetch gives kind 1 with fault address 0. A read or write gives kind 2 with fault address equal to the request address.
- R6: When 16 × id ≥ 2^(`ptab_szf` + 12), the request takes a storage fault with cause bit 30 set, and no memory read is made.
- R7: Storage faults are formatted by access type. A fetch gives kind 3 with fault address 0. A read or write gives kind 4 with fault address equal to the request address, and a write also sets cause bit 25.
- R8: The seed is decoded from the returned entry e:
  - root base = {8'b0, e[55:8], 8'b0};
  - root count = e[4:0];
  - space size = {e[62:61], e[7:5]} + 31;
  - `walk_ea` = request address with bits 63:62 cleared.

  `walk_start` is a one-cycle pulse.
- R9: A walk that completes without fault gives kind 0 with the walker's real address, page size and permissions.
- R10: A walk that completes with a fault gives a storage fault per R7, using the walker's cause.
- R11: `req_ready` is 0 while a request is in flight. The response fields hold steady while `rsp_valid` is 1 and `rsp_ready` is 0. Each accepted request yields exactly one response.
- R12: `mem_req_valid` is a one-cycle pulse, and no new read is issued before the previous one's data returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and accepting |
| req_acc | input | 2 | Access type |
| req_ir | input | 1 | Instruction relocation enable |
| req_dr | input | 1 | Data relocation enable |
| req_ea | input | 64 | Effective address |
| cur_pid | input | PID_W | Current process id |
| ptab_base | input | 64 | Process table base address |
| ptab_szf | input | SZF_W | Table size field, size = 2^(field+12) bytes |
| mem_req_valid | output | 1 | Memory read strobe |
| mem_req_addr | output | 64 | Memory read address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Read data |
| walk_start | output | 1 | Walk start pulse |
| walk_ea | output | 64 | Address to walk |
| walk_root_base | output | 64 | Root directory base |
| walk_root_cnt | output | 5 | Root directory entry-count field |
| walk_space | output | 6 | Address-space size |
| walk_done | input | 1 | Walk finished |
| walk_fault | input | 1 | Walk finished with fault |
| walk_cause | input | 32 | Walker fault cause |
| walk_raddr | input | 64 | Walker real address |
| walk_psize | input | 6 | Walker page size |
| walk_perm | input | 3 | Walker permissions |
| rsp_valid | output | 1 | Response held |
| rsp_ready | input | 1 | Response taken |
| rsp_kind | output | 3 | 0 ok, 1/2 segment fault, 3/4 storage fault, 5 bad access |
| rsp_cause | output | 32 | Fault cause |
| rsp_fault_addr | output | 64 | Fault address |
| rsp_raddr | output | 64 | Real address |
| rsp_psize | output | 6 | Page size (log2) |
| rsp_perm | output | 3 | Permissions |

## Verification
The hardest situation to reach is the boundary of the table-size check. One slot before the end must still produce a read, and the first slot at the end must fault without one. The vector table reaches it by setting `ptab_szf` and choosing an id just either side of 2^(field+8).

The bench's memory model builds entries whose root-count field is below the walker's minimum for id 0. Region-3 requests therefore drive a walker fault, and the R7/R10 formatting can be observed for reads, writes and fetches. A directed test holds `rsp_ready` low and offers a second request during the hold, to show the response stays put and only one is produced.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int EA_W    = 64;
  localparam int CAUSE_W = 32;
  localparam int PSZ_W   = 6;
  localparam int PERM_W  = 3;
  localparam int CNT_W   = 5;

  localparam logic [1:0] ACC_RD    = 2'b00;
  localparam logic [1:0] ACC_WR    = 2'b01;
  localparam logic [1:0] ACC_FETCH = 2'b10;
  localparam logic [1:0] ACC_BAD   = 2'b11;

  localparam logic [2:0] K_OK     = 3'd0;
  localparam logic [2:0] K_ISEG   = 3'd1;
  localparam logic [2:0] K_DSEG   = 3'd2;
  localparam logic [2:0] K_ISTOR  = 3'd3;
  localparam logic [2:0] K_DSTOR  = 3'd4;
  localparam logic [2:0] K_BADACC = 3'd5;

  localparam int CAUSE_NOTRANS_BIT = 30;
  localparam int CAUSE_STORE_BIT   = 25;

  localparam logic [EA_W-1:0] REAL_MASK = 64'h0FFF_FFFF_FFFF_FFFF;

  typedef struct packed {
    logic [2:0]         kind;
    logic [CAUSE_W-1:0] cause;
    logic [EA_W-1:0]    faddr;
    logic [EA_W-1:0]    raddr;
    logic [PSZ_W-1:0]   psize;
    logic [PERM_W-1:0]  perm;
  } rsp_t;
endpackage

// File: rtl/xlate_classify.sv
module xlate_classify
  import xlate_pkg::*;
#(
  parameter int PID_W = 20,
  parameter int SZF_W = 5
) (
  input  logic [1:0]       acc,
  input  logic             ir,
  input  logic             dr,
  input  logic [1:0]       quad,
  input  logic [PID_W-1:0] cur_pid,
  input  logic [SZF_W-1:0] szf,
  output logic             is_bad,
  output logic             is_real,
  output logic             is_illq,
  output logic             is_oob,
  output logic [EA_W-1:0]  tbl_off
);
  localparam int SH_W = SZF_W + 2;

  logic             fetch;
  logic [PID_W-1:0] sel_pid;
  logic [SH_W-1:0]  shamt;
  logic [EA_W-1:0]  limit;

  always_comb begin
    fetch   = (acc == ACC_FETCH);
    is_bad  = (acc == ACC_BAD);
    is_real = !is_bad && (fetch ? !ir : !dr);
    is_illq = (quad == 2'd1) || (quad == 2'd2);
    sel_pid = (quad == 2'd0) ? cur_pid : '0;
    tbl_off = {{(EA_W-PID_W-4){1'b0}}, sel_pid, 4'b0000};
    shamt   = SH_W'(szf) + SH_W'(12);
    limit   = 64'd1 << shamt;
    is_oob  = (tbl_off >= limit);
  end
endmodule

// File: rtl/xlate_fault_fmt.sv
module xlate_fault_fmt
  import xlate_pkg::*;
(
  input  logic [1:0]         acc,
  input  logic [EA_W-1:0]    ea,
  input  logic               seg,
  input  logic [CAUSE_W-1:0] cause_in,
  output rsp_t               flt
);
  logic fetch;
  always_comb begin
    fetch = (acc == ACC_FETCH);
    flt   = '0;
    if (seg) begin
      flt.kind  = fetch ? K_ISEG : K_DSEG;
      flt.faddr = fetch ? '0 : ea;
    end else begin
      flt.kind  = fetch ? K_ISTOR : K_DSTOR;
      flt.faddr = fetch ? '0 : ea;
      flt.cause = cause_in;
      if (acc == ACC_WR) flt.cause[CAUSE_STORE_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/xlate_entry_decode.sv
module xlate_entry_decode
  import xlate_pkg::*;
(
  input  logic [EA_W-1:0]  entry,
  output logic [EA_W-1:0]  root_base,
  output logic [CNT_W-1:0] root_cnt,
  output logic [PSZ_W-1:0] space
);
  logic unused_rsv;
  assign unused_rsv = ^{entry[63], entry[60:56]};

  always_comb begin
    root_base = {8'h00, entry[55:8], 8'h00};
    root_cnt  = entry[4:0];
    space     = PSZ_W'({entry[62:61], entry[7:5]}) + PSZ_W'(31);
  end
endmodule

// File: rtl/xlate_frontend.sv
module xlate_frontend
  import xlate_pkg::*;
#(
  parameter int PID_W      = 20,
  parameter int SZF_W      = 5,
  parameter int REAL_PSIZE = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_acc,
  input  logic               req_ir,
  input  logic               req_dr,
  input  logic [EA_W-1:0]    req_ea,
  input  logic [PID_W-1:0]   cur_pid,
  input  logic [EA_W-1:0]    ptab_base,
  input  logic [SZF_W-1:0]   ptab_szf,
  output logic               mem_req_valid,
  output logic [EA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [EA_W-1:0]    mem_rsp_data,
  output logic               walk_start,
  output logic [EA_W-1:0]    walk_ea,
  output logic [EA_W-1:0]    walk_root_base,
  output logic [CNT_W-1:0]   walk_root_cnt,
  output logic [PSZ_W-1:0]   walk_space,
  input  logic               walk_done,
  input  logic               walk_fault,
  input  logic [CAUSE_W-1:0] walk_cause,
  input  logic [EA_W-1:0]    walk_raddr,
  input  logic [PSZ_W-1:0]   walk_psize,
  input  logic [PERM_W-1:0]  walk_perm,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [2:0]         rsp_kind,
  output logic [CAUSE_W-1:0] rsp_cause,
  output logic [EA_W-1:0]    rsp_fault_addr,
  output logic [EA_W-1:0]    rsp_raddr,
  output logic [PSZ_W-1:0]   rsp_psize,
  output logic [PERM_W-1:0]  rsp_perm
);
  typedef enum logic [2:0] {S_IDLE, S_MREQ, S_MWAIT, S_WSTART, S_WWAIT, S_RESP} st_e;

  st_e               state;
  logic [1:0]        acc_q;
  logic [EA_W-1:0]   ea_q;
  logic [EA_W-1:0]   maddr_q;
  logic [EA_W-1:0]   seed_base_q;
  logic [CNT_W-1:0]  seed_cnt_q;
  logic [PSZ_W-1:0]  seed_space_q;
  rsp_t              rsp_q;
  rsp_t              rsp_nxt;
  rsp_t              flt;

  logic              c_bad, c_real, c_illq, c_oob;
  logic [EA_W-1:0]   c_off;
  logic              idle, finish;
  logic [EA_W-1:0]   d_base;
  logic [CNT_W-1:0]  d_cnt;
  logic [PSZ_W-1:0]  d_space;
  logic [1:0]        f_acc;
  logic [EA_W-1:0]   f_ea;
  logic [CAUSE_W-1:0] f_cause;
  logic              f_seg;

  assign idle = (state == S_IDLE);

  xlate_classify #(.PID_W(PID_W), .SZF_W(SZF_W)) u_cls (
    .acc(req_acc), .ir(req_ir), .dr(req_dr), .quad(req_ea[63:62]),
    .cur_pid(cur_pid), .szf(ptab_szf),
    .is_bad(c_bad), .is_real(c_real), .is_illq(c_illq), .is_oob(c_oob),
    .tbl_off(c_off)
  );

  always_comb begin
    f_acc   = idle ? req_acc : acc_q;
    f_ea    = idle ? req_ea  : ea_q;
    f_seg   = idle && c_illq;
    f_cause = idle ? (CAUSE_W'(1) << CAUSE_NOTRANS_BIT) : walk_cause;
  end

  xlate_fault_fmt u_fmt (
    .acc(f_acc), .ea(f_ea), .seg(f_seg), .cause_in(f_cause), .flt(flt)
  );

  xlate_entry_decode u_dec (
    .entry(mem_rsp_data), .root_base(d_base), .root_cnt(d_cnt), .space(d_space)
  );

  always_comb begin
    rsp_nxt = '0;
    finish  = 1'b0;
    if (idle) begin
      if (req_valid) begin
        if (c_bad) begin
          finish        = 1'b1;
          rsp_nxt.kind  = K_BADACC;
          rsp_nxt.faddr = req_ea;
        end else if (c_real) begin
          finish        = 1'b1;
          rsp_nxt.raddr = req_ea & REAL_MASK;
          rsp_nxt.psize = PSZ_W'(REAL_PSIZE);
          rsp_nxt.perm  = 3'b111;
        end else if (c_illq || c_oob) begin
          finish  = 1'b1;
          rsp_nxt = flt;
        end
      end
    end else if (state == S_WWAIT && walk_done) begin
      finish = 1'b1;
      if (walk_fault) begin
        rsp_nxt = flt;
      end else begin
        rsp_nxt.raddr = walk_raddr;
        rsp_nxt.psize = walk_psize;
        rsp_nxt.perm  = walk_perm;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      acc_q        <= '0;
      ea_q         <= '0;
      maddr_q      <= '0;
      seed_base_q  <= '0;
      seed_cnt_q   <= '0;
      seed_space_q <= '0;
      rsp_q        <= '0;
    end else begin
      if (finish) rsp_q <= rsp_nxt;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            acc_q <= req_acc;
            ea_q  <= req_ea;
            if (finish) state <= S_RESP;
            else begin
              maddr_q <= ptab_base + c_off;
              state   <= S_MREQ;
            end
          end
        end
        S_MREQ:   state <= S_MWAIT;
        S_MWAIT: begin
          if (mem_rsp_valid) begin
            seed_base_q  <= d_base;
            seed_cnt_q   <= d_cnt;
            seed_space_q <= d_space;
            state        <= S_WSTART;
          end
        end
        S_WSTART: state <= S_WWAIT;
        S_WWAIT:  if (walk_done) state <= S_RESP;
        S_RESP:   if (rsp_ready) state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign req_ready      = idle;
  assign mem_req_valid  = (state == S_MREQ);
  assign mem_req_addr   = maddr_q;
  assign walk_start     = (state == S_WSTART);
  assign walk_ea        = {2'b00, ea_q[61:0]};
  assign walk_root_base = seed_base_q;
  assign walk_root_cnt  = seed_cnt_q;
  assign walk_space     = seed_space_q;
  assign rsp_valid      = (state == S_RESP);
  assign rsp_kind       = rsp_q.kind;
  assign rsp_cause      = rsp_q.cause;
  assign rsp_fault_addr = rsp_q.faddr;
  assign rsp_raddr      = rsp_q.raddr;
  assign rsp_psize      = rsp_q.psize;
  assign rsp_perm       = rsp_q.perm;
endmodule

// File: rtl/xlate_frontend_chk.sv
module xlate_frontend_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_acc,
  input logic        req_ir,
  input logic        req_dr,
  input logic [1:0]  req_quad,
  input logic        mem_req_valid,
  input logic        mem_rsp_valid,
  input logic        walk_start,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [2:0]  rsp_kind,
  input logic [63:0] rsp_raddr,
  input logic [31:0] rsp_cause,
  input logic [2:0]  rsp_perm
);
  logic accept, real_req, outstanding;
  assign accept   = req_valid && req_ready;
  assign real_req = (req_acc != 2'b11) && ((req_acc == 2'b10) ? !req_ir : !req_dr);

  always_ff @(posedge clk) begin
    if (rst) outstanding <= 1'b0;
    else if (mem_req_valid) outstanding <= 1'b1;
    else if (mem_rsp_valid) outstanding <= 1'b0;
  end

  p_busy_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_raddr) &&
                                   $stable(rsp_kind) && $stable(rsp_cause)));

  p_mem_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  p_one_read_r12: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !outstanding);

  p_walk_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    walk_start |=> !walk_start);

  p_badacc_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && req_acc == 2'b11) |=> (rsp_valid && rsp_kind == 3'd5));

  p_real_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && real_req) |=> (rsp_valid && rsp_kind == 3'd0 &&
                              rsp_raddr[63:60] == 4'h0 && rsp_perm == 3'b111));

  p_seg_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && req_acc != 2'b11 && !real_req && (req_quad == 2'd1 || req_quad == 2'd2))
      |=> (rsp_valid && (rsp_kind == 3'd1 || rsp_kind == 3'd2) && rsp_cause == 32'd0));
endmodule

bind xlate_frontend xlate_frontend_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_acc(req_acc), .req_ir(req_ir), .req_dr(req_dr), .req_quad(req_ea[63:62]),
  .mem_req_valid(mem_req_valid), .mem_rsp_valid(mem_rsp_valid),
  .walk_start(walk_start), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_kind(rsp_kind), .rsp_raddr(rsp_raddr), .rsp_cause(rsp_cause),
  .rsp_perm(rsp_perm)
);

// File: tb/xlate_frontend_test.sv
module xlate_frontend_test;
  localparam logic [63:0] PT_BASE = 64'h0000_0000_0010_0000;
  localparam logic [31:0] WCAUSE  = 32'h0008_0000;

  typedef struct packed {
    logic [1:0]  acc;
    logic        ir;
    logic        dr;
    logic [4:0]  szf;
    logic [19:0] pid;
    logic [63:0] ea;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 1'b0, 5'd0, 20'd3,   64'hF123_4567_89AB_CDEF},
    '{2'b10, 1'b0, 1'b1, 5'd0, 20'd3,   64'h8000_0000_0000_1234},
    '{2'b00, 1'b0, 1'b1, 5'd0, 20'd5,   64'h0000_1234_5678_9ABC},
    '{2'b01, 1'b0, 1'b1, 5'd0, 20'd7,   64'hC000_0000_0040_0FF0},
    '{2'b10, 1'b1, 1'b0, 5'd0, 20'd7,   64'hC000_0000_0000_2000},
    '{2'b00, 1'b0, 1'b1, 5'd0, 20'd1,   64'h4000_0000_0000_0010},
    '{2'b10, 1'b1, 1'b1, 5'd0, 20'd1,   64'h8000_0000_0000_0020},
    '{2'b01, 1'b0, 1'b1, 5'd0, 20'd256, 64'h0000_0000_0000_3000},
    '{2'b00, 1'b0, 1'b1, 5'd0, 20'd255, 64'h0000_0000_0000_4008},
    '{2'b11, 1'b1, 1'b1, 5'd0, 20'd1,   64'h0000_0000_ABCD_0000},
    '{2'b10, 1'b1, 1'b0, 5'd1, 20'd20,  64'h0000_0ABC_DEF0_1234},
    '{2'b10, 1'b1, 1'b1, 5'd1, 20'd600, 64'h0000_0000_0000_5000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_acc = '0;
  logic        req_ir = 1'b0, req_dr = 1'b0;
  logic [63:0] req_ea = '0;
  logic [19:0] cur_pid = '0;
  logic [63:0] ptab_base = PT_BASE;
  logic [4:0]  ptab_szf = '0;
  logic        mem_req_valid;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        walk_start;
  logic [63:0] walk_ea, walk_root_base;
  logic [4:0]  walk_root_cnt;
  logic [5:0]  walk_space;
  logic        walk_done = 1'b0, walk_fault = 1'b0;
  logic [31:0] walk_cause = '0;
  logic [63:0] walk_raddr = '0;
  logic [5:0]  walk_psize = '0;
  logic [2:0]  walk_perm = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [2:0]  rsp_kind;
  logic [31:0] rsp_cause;
  logic [63:0] rsp_fault_addr, rsp_raddr;
  logic [5:0]  rsp_psize;
  logic [2:0]  rsp_perm;

  int checks = 0, fails = 0, cyc = 0;

  xlate_frontend uut (.*);

  always #2 clk = ~clk;

  function automatic logic [63:0] mem_word(input logic [63:0] addr);
    logic [19:0] pid;
    logic [19:0] t;
    logic [4:0]  rts, cnt;
    logic [47:0] b;
    pid = 20'((addr - PT_BASE) >> 4);
    t   = pid * 3;
    rts = t[4:0];
    cnt = pid[4:0] + 5'd4;
    b   = 48'h000A_0000 + 48'(pid);
    return {1'b0, rts[4:3], 5'b0, b, rts[2:0], cnt};
  endfunction

  // memory model: answers two negedges after the strobe
  int m_cnt = 0, nreads = 0, mem_bad = 0;
  logic [63:0] m_addr = '0, last_raddr = '0;
  logic m_prev = 1'b0;
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (mem_req_valid && (m_prev || m_cnt != 0)) mem_bad++;
    m_prev = mem_req_valid;
    if (mem_req_valid) begin
      m_addr = mem_req_addr; last_raddr = mem_req_addr; m_cnt = 2; nreads++;
    end else if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = mem_word(m_addr); end
    end
  end

  // walker model
  int w_cnt_dn = 0, wstarts = 0, walk_bad = 0;
  logic w_prev = 1'b0;
  logic [63:0] s_ea, s_base;
  logic [4:0]  s_cnt;
  logic [5:0]  s_space;
  always @(negedge clk) begin
    walk_done = 1'b0; walk_fault = 1'b0;
    if (walk_start && w_prev) walk_bad++;
    w_prev = walk_start;
    if (walk_start) begin
      s_ea = walk_ea; s_base = walk_root_base; s_cnt = walk_root_cnt; s_space = walk_space;
      w_cnt_dn = 3; wstarts++;
    end else if (w_cnt_dn > 0) begin
      w_cnt_dn--;
      if (w_cnt_dn == 0) begin
        walk_done = 1'b1;
        if (s_cnt < 5) begin walk_fault = 1'b1; walk_cause = WCAUSE; end
        else begin
          walk_raddr = {s_base[63:12], s_ea[11:0]};
          walk_psize = s_space - 6'(s_cnt);
          walk_perm  = 3'b101;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic model(input vec_t v, output logic [2:0] kind, output logic [31:0] cause,
                       output logic [63:0] faddr, output logic [63:0] raddr,
                       output logic [5:0] psize, output logic [2:0] perm,
                       output logic rd, output logic [63:0] rdaddr,
                       output logic [63:0] sbase, output logic [4:0] scnt, output logic [5:0] sspace);
    logic fetch, stor;
    logic [1:0] q;
    logic [19:0] pid, t;
    logic [31:0] sc;
    kind = 0; cause = 0; faddr = 0; raddr = 0; psize = 0; perm = 0;
    rd = 0; rdaddr = 0; sbase = 0; scnt = 0; sspace = 0; stor = 0; sc = 0;
    fetch = (v.acc == 2'b10); q = v.ea[63:62];
    if (v.acc == 2'b11) begin kind = 5; faddr = v.ea; end
    else if (fetch ? !v.ir : !v.dr) begin
      raddr = v.ea & 64'h0FFF_FFFF_FFFF_FFFF; psize = 12; perm = 3'b111;
    end else if (q == 1 || q == 2) begin
      kind = fetch ? 3'd1 : 3'd2; faddr = fetch ? 64'd0 : v.ea;
    end else begin
      pid = (q == 0) ? v.pid : 20'd0;
      if ((64'(pid) << 4) >= (64'd1 << (v.szf + 12))) begin stor = 1; sc = 32'h4000_0000; end
      else begin
        rd = 1; rdaddr = PT_BASE + (64'(pid) << 4);
        t = pid * 3;
        scnt = pid[4:0] + 5'd4;
        sspace = 6'(t[4:0]) + 6'd31;
        sbase = {8'h00, 48'h000A_0000 + 48'(pid), 8'h00};
        if (scnt < 5) begin stor = 1; sc = WCAUSE; end
        else begin
          raddr = {sbase[63:12], v.ea[11:0]}; psize = sspace - 6'(scnt); perm = 3'b101;
        end
      end
      if (stor) begin
        kind = fetch ? 3'd3 : 3'd4; faddr = fetch ? 64'd0 : v.ea;
        cause = sc | ((v.acc == 2'b01) ? 32'h0200_0000 : 32'd0);
      end
    end
  endtask

  string vtag [NV] = '{"R3", "R3", "R4 R9", "R4 R7 R10", "R10 R7", "R5", "R5",
                       "R6 R7", "R6 R10", "R2", "R9", "R6"};

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 req_ready in reset", 64'(req_ready), 64'd1);
    chk("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle outputs after reset", {61'd0, rsp_valid, mem_req_valid, walk_start}, 64'd0);
    chk("R1 req_ready after reset", 64'(req_ready), 64'd1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [2:0] ek, ep; logic [31:0] ec; logic [63:0] ef, er, era, eb;
      logic [5:0] eps, esp; logic erd; logic [4:0] ecn;
      int r0, w0, wd;
      string tg;
      v = VECS[i]; tg = vtag[i];
      model(v, ek, ec, ef, er, eps, ep, erd, era, eb, ecn, esp);
      r0 = nreads; w0 = wstarts;
      req_acc = v.acc; req_ir = v.ir; req_dr = v.dr; req_ea = v.ea;
      cur_pid = v.pid; ptab_szf = v.szf; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      wd = 0;
      while (!rsp_valid && wd < 200) begin @(negedge clk); wd++; end
      chk({tg, " response arrives"}, 64'(rsp_valid), 64'd1);
      chk({tg, " kind"}, 64'(rsp_kind), 64'(ek));
      chk({tg, " cause"}, 64'(rsp_cause), 64'(ec));
      chk({tg, " fault addr"}, rsp_fault_addr, ef);
      chk({tg, " raddr"}, rsp_raddr, er);
      chk({tg, " psize/perm"}, {55'd0, rsp_psize, rsp_perm}, {55'd0, eps, ep});
      chk({tg, " memory reads"}, 64'(nreads - r0), 64'(erd));
      if (erd) begin
        chk("R4 table read address", last_raddr, era);
        chk("R8 walk seed base", s_base, eb);
        chk("R8 walk seed count/space", {53'd0, s_cnt, s_space}, {53'd0, ecn, esp});
        chk("R8 walk ea", s_ea, {2'b00, v.ea[61:0]});
        chk("R8 one walk start", 64'(wstarts - w0), 64'd1);
      end
      @(negedge clk);
      chk({tg, " R11 single response"}, 64'(rsp_valid), 64'd0);
    end

    // R11/R3: backpressure, latency and a request offered during the hold
    rsp_ready = 1'b0;
    req_acc = 2'b00; req_dr = 1'b0; req_ea = 64'hABCD_0000_1111_2222; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R3 response one cycle after accept", 64'(rsp_valid), 64'd1);
    chk("R3 real address", rsp_raddr, 64'h0BCD_0000_1111_2222);
    req_ea = 64'h0000_0000_9999_0000; req_acc = 2'b01;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11 held valid", 64'(rsp_valid), 64'd1);
      chk("R11 held raddr", rsp_raddr, 64'h0BCD_0000_1111_2222);
      chk("R11 not ready while busy", 64'(req_ready), 64'd0);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 exactly one response", 64'(rsp_valid), 64'd0);
    chk("R11 ready again", 64'(req_ready), 64'd1);
    repeat (3) @(negedge clk);
    chk("R11 no late response", 64'(rsp_valid), 64'd0);

    chk("R12 read strobe pulse and single outstanding", 64'(mem_bad), 64'd0);
    chk("R8 walk start pulse", 64'(walk_bad), 64'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule